// File: doc/BRIEF.md
# Compressed Program Counter Trace Buffer

This block records the program counter values a CPU reports into a small circular line memory, so that the recent flow of execution can be rebuilt after a stop. Capture runs while the enable input is high. In plain mode each accepted PC takes one 20-bit line, together with a destination flag and a vector flag. In compressed mode the block stores a full 18-bit base address. It then packs up to three 6-bit PC offsets into each later line, for as long as the PCs stay in the same 64-address page as that base.

A compressed line carries a 2-bit tag in bits 19:18. Tag 00 marks a base line, and the PC sits in bits 17:0. Tags 01, 10 and 11 give the number of offsets the line holds. Offsets fill slot 0 (bits 5:0) first, then slot 1 (bits 11:6), then slot 2 (bits 17:12). A PC that leaves the current page commits any partly filled line and writes a new base line in the same cycle. Dropping the enable also commits a partly filled line.

The write pointer always names the next line to be written. Once the pointer has rolled over, a sticky flag is set, and the pointer then also marks the oldest line. A reader starts there and skips forward to the first base line. The readout port returns the line at the requested address in the same cycle.

Top module: `pctb_trace_buf`

## Requirements
- R1: While reset is asserted, the write pointer is 0, the wrapped flag is 0 and every memory line reads 0.
- R2: In plain mode (compress_mode = 0) each accepted PC writes one line: bit 19 is the destination flag, bit 18 is the vector flag, and bits 17:0 hold the PC.
- R3: In plain mode, a PC presented with the vector flag set is stored with bit 19 set, even when the destination input is low.
- R4: In compressed mode, the first PC accepted after the enable rises is written as a base line: tag 00 in bits 19:18 and the PC in bits 17:0.
- R5: In compressed mode, a PC whose bits 17:6 equal those of the current base contributes only its bits 5:0. These fill slots 0, 1 and 2 (bits 5:0, 11:6, 17:12) in arrival order, and the line is written with tag 11 once the third slot is filled.
- R6: A compressed-mode PC outside the current page writes a new base line. If a line is partly filled, that line is first written with tag 01 (one slot) or 10 (two slots), with its unused slots zero, and the new base line goes to the next address in the same cycle.
- R7: When the enable falls, a partly filled line is written with its count tag. After the enable rises again, compressed capture starts over with a new base line.
- R8: The write pointer advances by the number of lines written in the cycle, modulo the depth. A rising enable restarts the pointer at line 0 and clears the wrapped flag.
- R9: The wrapped flag sets on the first pointer rollover and stays set until the next restart or reset.
- R10: A PC-valid strobe while the enable is low writes no line and leaves the pointer unchanged.
- R11: rd_data returns the content of line rd_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Capture enable; a rising edge restarts capture |
| compress_mode | input | 1 | 1 = compressed format, 0 = plain format |
| pc_vld | input | 1 | PC strobe |
| pc | input | 18 | Program counter value |
| is_dest | input | 1 | PC is a destination address |
| is_vec | input | 1 | PC is a vector destination |
| rd_addr | input | AW | Readout line address |
| rd_data | output | 20 | Line content at rd_addr |
| wr_ptr | output | AW | Next line to write; the oldest line once wrapped |
| wrapped | output | 1 | Sticky rollover indication |

## Verification
The bench targets a page change that arrives while one or two offsets are pending. A design that wrote only one line there would lose either the partial line or the new base, and the rebuilt PC stream would then disagree with the captured one. Long compressed runs wrap the memory several times, including two-line writes that straddle the last address. This exposes pointer arithmetic that drops the carry or never sets the wrapped flag. Stopping capture with pending offsets, and then restarting, shows whether a partial line is lost or whether a stale base is reused. A vector PC presented without the destination flag catches a design that stores the flags unchanged.

// File: rtl/pctb_pkg.sv
package pctb_pkg;
  localparam int PC_W   = 18;
  localparam int OFS_W  = 6;
  localparam int SLOTS  = 3;
  localparam int TAG_W  = 2;
  localparam int HI_W   = PC_W - OFS_W;
  localparam int LINE_W = TAG_W + SLOTS * OFS_W;

  typedef logic [PC_W-1:0]         pc_t;
  typedef logic [LINE_W-1:0]       line_t;
  typedef logic [SLOTS*OFS_W-1:0]  slots_t;

  localparam logic [TAG_W-1:0] TAG_BASE = 2'b00;

  function automatic line_t pack_base(pc_t p);
    return {TAG_BASE, p};
  endfunction

  // a vector target is always a destination
  function automatic line_t pack_plain(pc_t p, logic dst, logic vec);
    return {dst | vec, vec, p};
  endfunction

  function automatic logic same_page(pc_t p, logic [HI_W-1:0] hi);
    return p[PC_W-1:OFS_W] == hi;
  endfunction

  function automatic line_t pack_slots(logic [TAG_W-1:0] cnt, slots_t s);
    return {cnt, s};
  endfunction

  function automatic slots_t put_slot(slots_t s, logic [1:0] idx, logic [OFS_W-1:0] ofs);
    slots_t r;
    r = s;
    for (int k = 0; k < SLOTS; k++)
      if (idx == 2'(k)) r[k*OFS_W +: OFS_W] = ofs;
    return r;
  endfunction
endpackage

// File: rtl/pctb_packer.sv
module pctb_packer
  import pctb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trace_en,
  input  logic       compress_mode,
  input  logic       pc_vld,
  input  pc_t        pc,
  input  logic       is_dest,
  input  logic       is_vec,
  output logic       start,
  output logic       en_q,
  output logic [1:0] wr_n,
  output line_t      line_a,
  output line_t      line_b,
  output logic [1:0] fill_cnt
);
  logic            have_base, have_n;
  logic [HI_W-1:0] base_hi, hi_n;
  logic [1:0]      cnt_n, cnt_eff;
  slots_t          slots, slots_n;
  logic            hb_eff, accept, flush, hit;

  assign start   = trace_en & ~en_q;
  assign flush   = ~trace_en & en_q & (fill_cnt != 2'd0);
  assign accept  = trace_en & pc_vld;
  assign cnt_eff = start ? 2'd0 : fill_cnt;
  assign hb_eff  = have_base & ~start;
  assign hit     = hb_eff & same_page(pc, base_hi);

  always_comb begin
    wr_n    = 2'd0;
    line_a  = '0;
    line_b  = '0;
    have_n  = hb_eff & trace_en;
    hi_n    = base_hi;
    cnt_n   = cnt_eff;
    slots_n = start ? '0 : slots;
    if (flush) begin
      line_a  = pack_slots(fill_cnt, slots);
      wr_n    = 2'd1;
      cnt_n   = 2'd0;
      slots_n = '0;
    end else if (accept) begin
      if (!compress_mode) begin
        line_a = pack_plain(pc, is_dest, is_vec);
        wr_n   = 2'd1;
      end else if (hit) begin
        if (cnt_eff == 2'(SLOTS-1)) begin
          line_a  = pack_slots(2'(SLOTS), put_slot(slots_n, cnt_eff, pc[OFS_W-1:0]));
          wr_n    = 2'd1;
          cnt_n   = 2'd0;
          slots_n = '0;
        end else begin
          slots_n = put_slot(slots_n, cnt_eff, pc[OFS_W-1:0]);
          cnt_n   = cnt_eff + 2'd1;
        end
      end else begin
        if (cnt_eff != 2'd0) begin
          line_a = pack_slots(cnt_eff, slots_n);
          line_b = pack_base(pc);
          wr_n   = 2'd2;
        end else begin
          line_a = pack_base(pc);
          wr_n   = 2'd1;
        end
        hi_n    = pc[PC_W-1:OFS_W];
        have_n  = 1'b1;
        cnt_n   = 2'd0;
        slots_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      have_base <= 1'b0;
      base_hi   <= '0;
      fill_cnt  <= 2'd0;
      slots     <= '0;
    end else begin
      en_q      <= trace_en;
      have_base <= have_n;
      base_hi   <= hi_n;
      fill_cnt  <= cnt_n;
      slots     <= slots_n;
    end
  end
endmodule

// File: rtl/pctb_ptr.sv
module pctb_ptr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    wr_n,
  output logic [AW-1:0] cur_ptr,
  output logic [AW-1:0] wr_ptr,
  output logic          wrapped
);
  logic [AW:0] sum;

  assign cur_ptr = start ? '0 : wr_ptr;
  assign sum     = {1'b0, cur_ptr} + (AW+1)'(wr_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      wrapped <= 1'b0;
    end else begin
      wr_ptr  <= sum[AW-1:0];
      wrapped <= (wrapped & ~start) | sum[AW];
    end
  end
endmodule

// File: rtl/pctb_linemem.sv
module pctb_linemem
  import pctb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    wr_n,
  input  logic [AW-1:0] addr_a,
  input  line_t         line_a,
  input  line_t         line_b,
  input  logic [AW-1:0] rd_addr,
  output line_t         rd_data
);
  line_t         mem [DEPTH];
  logic [AW-1:0] addr_b;
  logic          we_a, we_b;

  assign addr_b  = addr_a + AW'(1);
  assign we_a    = wr_n != 2'd0;
  assign we_b    = wr_n == 2'd2;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)                         mem[i] <= '0;
      else if (we_a && addr_a == AW'(i))  mem[i] <= line_a;
      else if (we_b && addr_b == AW'(i))  mem[i] <= line_b;
    end
  end
endmodule

// File: rtl/pctb_trace_buf.sv
module pctb_trace_buf
  import pctb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              compress_mode,
  input  logic              pc_vld,
  input  logic [PC_W-1:0]   pc,
  input  logic              is_dest,
  input  logic              is_vec,
  input  logic [AW-1:0]     rd_addr,
  output logic [LINE_W-1:0] rd_data,
  output logic [AW-1:0]     wr_ptr,
  output logic              wrapped
);
  logic          start, en_q;
  logic [1:0]    wr_n, fill_cnt;
  line_t         line_a, line_b;
  logic [AW-1:0] cur_ptr;

  pctb_packer u_pack (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .compress_mode(compress_mode),
    .pc_vld(pc_vld), .pc(pc), .is_dest(is_dest), .is_vec(is_vec),
    .start(start), .en_q(en_q), .wr_n(wr_n), .line_a(line_a), .line_b(line_b),
    .fill_cnt(fill_cnt)
  );

  pctb_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_n(wr_n),
    .cur_ptr(cur_ptr), .wr_ptr(wr_ptr), .wrapped(wrapped)
  );

  pctb_linemem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr_a(cur_ptr),
    .line_a(line_a), .line_b(line_b), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/pctb_checker.sv
module pctb_checker #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trace_en,
  input logic          compress_mode,
  input logic          pc_vld,
  input logic          start,
  input logic          en_q,
  input logic [1:0]    wr_n,
  input logic [19:0]   line_a,
  input logic [1:0]    fill_cnt,
  input logic [AW-1:0] wr_ptr,
  input logic          wrapped
);
  assert_vec_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && pc_vld && !compress_mode && wr_n != 2'd0 && line_a[18]) |-> line_a[19]);

  assert_first_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pc_vld && compress_mode) |-> (wr_n == 2'd1 && line_a[19:18] == 2'b00));

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt != 2'd3);

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_en && en_q) |=> fill_cnt == 2'd0);

  assert_restart_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> wr_ptr == AW'($past(wr_n)));

  assert_wrap_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !start) |=> wrapped);

  assert_idle_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_en && !en_q) |=> $stable(wr_ptr));
endmodule

bind pctb_trace_buf pctb_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .compress_mode(compress_mode),
  .pc_vld(pc_vld), .start(start), .en_q(en_q), .wr_n(wr_n), .line_a(line_a),
  .fill_cnt(fill_cnt), .wr_ptr(wr_ptr), .wrapped(wrapped)
);

// File: tb/sim_pctb_trace_buf.sv
`timescale 1ns/1ps
module sim_pctb_trace_buf;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trace_en = 1'b0, compress_mode = 1'b0, pc_vld = 1'b0;
  logic [17:0]   pc = '0;
  logic          is_dest = 1'b0, is_vec = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [19:0]   rd_data;
  logic [AW-1:0] wr_ptr;
  logic          wrapped;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic [19:0] mem_m [DEPTH];
  int          m_ptr = 0;
  bit          m_wrap = 0, m_have = 0;
  logic [11:0] m_base = '0;
  logic [5:0]  pend [$];
  logic [17:0] cap [$];

  always #4 clk = ~clk;

  pctb_trace_buf #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .compress_mode(compress_mode),
    .pc_vld(pc_vld), .pc(pc), .is_dest(is_dest), .is_vec(is_vec),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr), .wrapped(wrapped)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic void m_write(logic [19:0] ln);
    mem_m[m_ptr] = ln;
    m_ptr = (m_ptr + 1) % DEPTH;
    if (m_ptr == 0) m_wrap = 1;
  endfunction

  function automatic void m_flush();
    logic [19:0] ln;
    if (pend.size() == 0) return;
    ln = '0;
    ln[19:18] = 2'(pend.size());
    foreach (pend[j]) ln[6*j +: 6] = pend[j];
    m_write(ln);
    pend.delete();
  endfunction

  function automatic void m_pc(logic [17:0] p, logic d, logic v, logic cmp);
    if (!cmp) m_write({d | v, v, p});
    else if (m_have && p[17:6] == m_base) begin
      pend.push_back(p[5:0]);
      if (pend.size() == 3) m_flush();
    end else begin
      m_flush();
      m_write({2'b00, p});
      m_have = 1;
      m_base = p[17:6];
    end
  endfunction

  task automatic arm(logic cmp);
    compress_mode = cmp;
    trace_en = 1'b1;
    m_ptr = 0; m_wrap = 0; m_have = 0; pend.delete();
    @(negedge clk);
  endtask

  task automatic disarm();
    trace_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    m_flush();
    m_have = 0;
  endtask

  task automatic send(logic [17:0] p, logic d, logic v);
    pc = p; is_dest = d; is_vec = v; pc_vld = 1'b1;
    m_pc(p, d, v, compress_mode);
    cap.push_back(p);
    @(negedge clk);
    pc_vld = 1'b0;
  endtask

  task automatic rd_line(int a, output logic [19:0] v);
    rd_addr = AW'(a);
    #1;
    v = rd_data;
  endtask

  task automatic cmp_mem(string req);
    logic [19:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd_line(i, v);
      check(req, v, mem_m[i]);
    end
  endtask

  // rebuild the PC stream from memory and compare with the captured tail
  task automatic rebuild(string req);
    logic [19:0] ln;
    logic [17:0] dec [$];
    logic [11:0] hi;
    int first, cnt, off;
    bit have;
    first = wrapped ? int'(wr_ptr) : 0;
    cnt   = wrapped ? DEPTH : int'(wr_ptr);
    have  = 0; hi = '0;
    for (int k = 0; k < cnt; k++) begin
      rd_line((first + k) % DEPTH, ln);
      if (ln[19:18] == 2'b00) begin
        have = 1; hi = ln[17:6]; dec.push_back(ln[17:0]);
      end else if (have) begin
        for (int j = 0; j < int'(ln[19:18]); j++) dec.push_back({hi, ln[6*j +: 6]});
      end
    end
    check({req, " rebuilt nonempty"}, 32'(dec.size() > 0), 32'd1);
    off = cap.size() - dec.size();
    foreach (dec[i]) check(req, dec[i], cap[off + i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [19:0] v;
    logic [17:0] cur;
    void'($urandom(32'h5EED_0C1A));
    foreach (mem_m[i]) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 ptr in reset", wr_ptr, 0);
    check("R1 wrapped in reset", wrapped, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_mem("R1 memory cleared");

    // plain mode directed
    arm(1'b0);
    send(18'h3FFFF, 1'b0, 1'b0);
    send(18'h10000, 1'b1, 1'b0);
    send(18'h00123, 1'b0, 1'b1);
    disarm();
    check("R8 ptr after plain", wr_ptr, 3);
    rd_line(0, v); check("R2 source line", v, 20'h3FFFF);
    rd_line(1, v); check("R2 dest line", v, 20'h90000);
    rd_line(2, v); check("R3 vector forces dest", v, 20'hC0123);

    // strobes while disabled are ignored
    pc = 18'h2AAAA; pc_vld = 1'b1;
    repeat (3) @(negedge clk);
    pc_vld = 1'b0;
    @(negedge clk);
    check("R10 ptr held", wr_ptr, 3);
    cmp_mem("R10 memory untouched");

    // compressed directed
    arm(1'b1);
    send(18'h12340, 1'b0, 1'b0);
    send(18'h12341, 1'b0, 1'b0);
    send(18'h12342, 1'b0, 1'b0);
    send(18'h12343, 1'b0, 1'b0);
    send(18'h12345, 1'b1, 1'b1);
    send(18'h00A80, 1'b0, 1'b0);
    send(18'h00A81, 1'b0, 1'b0);
    send(18'h00ABF, 1'b0, 1'b0);
    disarm();
    rd_line(0, v); check("R4 first base line", v, 20'h12340);
    rd_line(1, v); check("R5 full line tag 11", v, 20'hC3081);
    rd_line(2, v); check("R6 partial tag 01", v, 20'h40005);
    rd_line(3, v); check("R6 new base line", v, 20'h00A80);
    rd_line(4, v); check("R7 flushed tag 10", v, 20'h80FC1);
    check("R8 ptr after compressed", wr_ptr, 5);
    check("R9 not wrapped", wrapped, 0);
    cmp_mem("R5 compressed memory");

    // restart begins with a base line even on the same page
    arm(1'b1);
    send(18'h00A82, 1'b0, 1'b0);
    disarm();
    rd_line(0, v); check("R7 restart base", v, 20'h00A82);
    check("R8 restart ptr", wr_ptr, 1);

    // long random compressed run with rollover
    arm(1'b1);
    cap.delete();
    cur = 18'h05000;
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 4 == 0) cur = 18'($urandom);
      else cur = 18'(cur + 18'($urandom % 3));
      if ($urandom % 5 == 0) @(negedge clk);
      send(cur, 1'($urandom), 1'($urandom));
    end
    disarm();
    cmp_mem("R6 random compressed memory");
    check("R8 ptr after random", wr_ptr, m_ptr);
    check("R9 wrapped after rollover", wrapped, 32'(m_wrap));
    rd_line(0, v); check("R11 readout line 0", v, mem_m[0]);
    rebuild("R5 rebuilt stream");

    // random plain run with rollover
    arm(1'b0);
    check("R8 wrapped cleared on restart", wrapped, 0);
    for (int n = 0; n < 40; n++) send(18'($urandom), 1'($urandom), 1'($urandom));
    disarm();
    cmp_mem("R2 random plain memory");
    check("R9 plain wrap", wrapped, 1);
    check("R8 plain ptr", wr_ptr, m_ptr);

    done = 1;
    summary();
  end
endmodule